// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits behind the command decoder of a serial byte-addressed memory and handles the write command's data phase. When a write command opens, the block takes its start address. It then gathers each incoming data byte into a one-page holding buffer, and the slot pointer wraps inside the page. When chip select rises on a clean byte boundary, the block turns the buffered bytes into a self-timed program cycle on a 1024-byte array, which is modelled here as plain registers.

During the program cycle the block raises a busy flag for a fixed number of system clocks. In the first clocks of that window it walks the page offsets in order. An offset is written only if a byte arrived for it and the external permission input allows that address. Command traffic and array reads that arrive during the window are dropped. When the window closes, a single pulse tells the command layer to clear its write-enable latch. `PAGE_BYTES` must be 16 or 32, and `CYCLE_CLKS` must be at least `PAGE_BYTES`.

Top module: `pgw_top`

## Requirements
- R1: Of the 16-bit `cmd_addr`, only bits [9:0] form the byte address. Bits [15:10] do not affect which location is written. The page is address bits [9:log2(PAGE_BYTES)], and the starting slot is the low log2(PAGE_BYTES) bits.
- R2: Each accepted data byte goes to the current slot, and the slot then advances by one. After slot PAGE_BYTES-1 comes slot 0 of the same page. A later byte overwrites an earlier byte in the same slot, and no byte ever reaches another page.
- R3: A `cs_rise` with `bit_aligned` high, while a command is open and at least one byte is buffered, makes `busy` read 1 from the next clock on.
- R4: A `cs_rise` with `bit_aligned` low closes the command without a program cycle, and the buffered bytes never reach the array. Data bytes that arrive after that and before a new `cmd_start` are dropped.
- R5: A byte-aligned `cs_rise` after a command that carried no data byte starts no program cycle.
- R6: `busy` stays high for exactly CYCLE_CLKS clocks. While it is high, `cmd_start`, `byte_stb` and `cs_rise` have no effect, and no command is open when it falls.
- R7: In busy clock i (counting from 0), for i < PAGE_BYTES, `mem_addr` = {page, i}. `mem_we` is 1 only if slot i received a byte and `wr_ok` is high, and then `mem_wdata` is that byte. Locations not written keep their old contents.
- R8: A `rd_req` sampled while idle gives `rd_valid` = 1 and `rd_data` = the array byte at `rd_addr` on the next clock. A `rd_req` sampled while busy gives `rd_valid` = 0.
- R9: `wel_clr` is high for exactly one clock, the first clock after `busy` falls, and is low at all other times.
- R10: After a synchronous reset (`rst_n` low at a clock edge), `busy`, `wel_clr`, `mem_we` and `rd_valid` are 0, and every array byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Opens a write command and captures `cmd_addr` |
| cmd_addr | input | 16 | Start address field of the command |
| byte_stb | input | 1 | One complete data byte is present on `byte_data` |
| byte_data | input | 8 | Data byte |
| cs_rise | input | 1 | Chip select has risen (ends the command) |
| bit_aligned | input | 1 | Bit count was a whole number of bytes at `cs_rise` |
| wr_ok | input | 1 | Write permission for the address now on `mem_addr` |
| rd_req | input | 1 | Array read request |
| rd_addr | input | 10 | Array read address |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | 10 | Array write address |
| mem_wdata | output | 8 | Array write data |
| busy | output | 1 | Program cycle in progress |
| wel_clr | output | 1 | Pulse that clears the write-enable latch |

## Verification
The hardest situation to reach is a command that tries to open while a program cycle is still running. At the ports it looks exactly like a correct rejection, unless a later event would expose a command that was wrongly kept open. The stimulus therefore sends a start, a byte and an aligned rise during the busy window. After the window it sends one more aligned rise with no new start, expects no second cycle, and reads the addresses to confirm nothing moved. Slot wrap and per-address permission are reached by overrunning a page from a start slot near its top, and by moving the bench's protection limit into the middle of a page.

// File: rtl/pgw_pkg.sv
// Shared constants and types for the page write buffer.
package pgw_pkg;
    localparam int ADDR_W     = 10;  // byte address width of the array
    localparam int CMD_ADDR_W = 16;  // width of the command address field
    localparam int DATA_W     = 8;
    typedef logic [DATA_W-1:0] byte_t;
endpackage

// File: rtl/pgw_buffer.sv
// Page holding buffer: one data slot and one "received" flag per page offset.
// Opening a command clears the flags and loads the slot pointer.
// Each push fills the current slot and advances the pointer mod PAGE_BYTES.
// Assumes PAGE_BYTES is a power of two, so the pointer wraps on its own.
module pgw_buffer
    import pgw_pkg::*;
#(
    parameter int  PAGE_BYTES = 16,
    localparam int PW         = $clog2(PAGE_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          open_i,
    input  logic [PW-1:0] open_off_i,
    input  logic          push_i,
    input  byte_t         push_data_i,
    input  logic [PW-1:0] rd_idx_i,
    output byte_t         rd_data_o,
    output logic          rd_mask_o,
    output logic          any_o
);
    logic [PW-1:0]         ptr_q;
    logic [PAGE_BYTES-1:0] mask_q;
    byte_t                 data_q [PAGE_BYTES];

    // Slot pointer: load on open, step on push.
    always_ff @(posedge clk) begin
        if (!rst_n)      ptr_q <= '0;
        else if (open_i) ptr_q <= open_off_i;
        else if (push_i) ptr_q <= ptr_q + 1'b1;
    end

    // One slot per page offset.
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        // Fill slot g when the pointer selects it; flags clear on open.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_q[g] <= '0;
                mask_q[g] <= 1'b0;
            end else if (open_i) begin
                mask_q[g] <= 1'b0;
            end else if (push_i && ptr_q == PW'(g)) begin
                data_q[g] <= push_data_i;
                mask_q[g] <= 1'b1;
            end
        end
    end

    assign rd_data_o = data_q[rd_idx_i];
    assign rd_mask_o = mask_q[rd_idx_i];
    assign any_o     = |mask_q;

    // A push into the top slot must leave the pointer at slot 0.
    assert_slot_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !open_i && ptr_q == PW'(PAGE_BYTES-1)) |=> (ptr_q == '0));

    // A pushed slot reads as received on the next clock.
    assert_push_marks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !open_i) |=> mask_q[$past(ptr_q)]);
endmodule

// File: rtl/pgw_seq.sv
// Program-cycle sequencer. A commit starts a window of CYCLE_CLKS clocks with
// busy high. The window counter supplies the page offset swept in its first
// PAGE_BYTES clocks. After the window a one-clock latch-clear pulse follows.
// Assumes CYCLE_CLKS >= PAGE_BYTES.
module pgw_seq #(
    parameter int  PAGE_BYTES = 16,
    parameter int  CYCLE_CLKS = 50000,
    localparam int PW         = $clog2(PAGE_BYTES),
    localparam int CW         = $clog2(CYCLE_CLKS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit_i,
    output logic          busy_o,
    output logic [PW-1:0] idx_o,
    output logic          in_page_o,
    output logic          wel_clr_o
);
    logic          busy_q;
    logic          clr_q;
    logic [CW-1:0] cnt_q;
    logic          last_w;

    assign last_w = busy_q && (cnt_q == CW'(CYCLE_CLKS - 1));

    // Window timer: start on commit, stop after the last counted clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (busy_q) begin
            busy_q <= !last_w;
            cnt_q  <= last_w ? '0 : cnt_q + 1'b1;
        end else if (commit_i) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end
    end

    // Latch-clear pulse in the clock after the window ends.
    always_ff @(posedge clk) begin
        if (!rst_n) clr_q <= 1'b0;
        else        clr_q <= last_w;
    end

    assign busy_o    = busy_q;
    assign idx_o     = cnt_q[PW-1:0];
    assign in_page_o = busy_q && (cnt_q < CW'(PAGE_BYTES));
    assign wel_clr_o = clr_q;

    // The window closes only after its full length.
    assert_window_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> ($past(cnt_q) == CW'(CYCLE_CLKS - 1)));

    // Every end of window is followed by the clear pulse.
    assert_clear_after_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> clr_q);

    // The clear pulse lasts one clock.
    assert_clear_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_q |=> !clr_q);
endmodule

// File: rtl/pgw_array.sv
// Byte array held in plain registers, with one write port and one
// registered read port. Assumes the caller never asks for a read and a
// write in the same clock.
module pgw_array
    import pgw_pkg::*;
#(
    parameter int  AW    = ADDR_W,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  byte_t         wdata_i,
    input  logic          re_i,
    input  logic [AW-1:0] raddr_i,
    output logic          rvalid_o,
    output byte_t         rdata_o
);
    byte_t mem_q [DEPTH];

    // Storage: cleared by reset, written by the program sweep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    // Registered read: one clock from request to data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_o <= 1'b0;
            rdata_o  <= '0;
        end else begin
            rvalid_o <= re_i;
            if (re_i) rdata_o <= mem_q[raddr_i];
        end
    end
endmodule

// File: rtl/pgw_top.sv
// Page write buffer and commit. Tracks whether a write command is open and
// which page it targets. Data bytes go into the page buffer. The command
// commits on an aligned chip-select rise, and the sequencer then sweeps the
// buffer into the array. Priority within a clock: cs_rise, then cmd_start,
// then byte_stb. All three are ignored while busy.
module pgw_top
    import pgw_pkg::*;
#(
    parameter int  PAGE_BYTES = 16,
    parameter int  CYCLE_CLKS = 50000,
    localparam int PW         = $clog2(PAGE_BYTES),
    localparam int PGW        = ADDR_W - PW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_start,
    input  logic [CMD_ADDR_W-1:0] cmd_addr,
    input  logic                  byte_stb,
    input  logic [DATA_W-1:0]     byte_data,
    input  logic                  cs_rise,
    input  logic                  bit_aligned,
    input  logic                  wr_ok,
    input  logic                  rd_req,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic                  rd_valid,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [DATA_W-1:0]     mem_wdata,
    output logic                  busy,
    output logic                  wel_clr
);
    logic           open_q;
    logic [PGW-1:0] page_q;
    logic           acc_rise, acc_start, acc_byte, commit;
    logic           any_w, slot_mask_w, in_page_w;
    logic [PW-1:0]  idx_w;
    byte_t          slot_data_w;
    logic           unused_addr_hi;

    assign unused_addr_hi = ^cmd_addr[CMD_ADDR_W-1:ADDR_W];

    assign acc_rise  = cs_rise && !busy;
    assign acc_start = cmd_start && !busy && !cs_rise;
    assign acc_byte  = byte_stb && open_q && !busy && !cs_rise && !cmd_start;
    assign commit    = acc_rise && open_q && bit_aligned && any_w;

    // Command state: open on start, close on any chip-select rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            page_q <= '0;
        end else if (acc_rise) begin
            open_q <= 1'b0;
        end else if (acc_start) begin
            open_q <= 1'b1;
            page_q <= cmd_addr[ADDR_W-1:PW];
        end
    end

    pgw_buffer #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .open_i      (acc_start),
        .open_off_i  (cmd_addr[PW-1:0]),
        .push_i      (acc_byte),
        .push_data_i (byte_data),
        .rd_idx_i    (idx_w),
        .rd_data_o   (slot_data_w),
        .rd_mask_o   (slot_mask_w),
        .any_o       (any_w)
    );

    pgw_seq #(.PAGE_BYTES(PAGE_BYTES), .CYCLE_CLKS(CYCLE_CLKS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit_i  (commit),
        .busy_o    (busy),
        .idx_o     (idx_w),
        .in_page_o (in_page_w),
        .wel_clr_o (wel_clr)
    );

    assign mem_addr  = {page_q, idx_w};
    assign mem_wdata = slot_data_w;
    assign mem_we    = in_page_w && slot_mask_w && wr_ok;

    pgw_array #(.AW(ADDR_W)) u_arr (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (mem_we),
        .waddr_i  (mem_addr),
        .wdata_i  (mem_wdata),
        .re_i     (rd_req && !busy),
        .raddr_i  (rd_addr),
        .rvalid_o (rd_valid),
        .rdata_o  (rd_data)
    );

    // Array writes only happen inside the program window.
    assert_write_in_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // A valid commit starts the window on the next clock.
    assert_commit_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> busy);

    // The target page cannot change inside the window.
    assert_page_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(page_q));

    // No read result is produced for a request made while busy.
    assert_no_read_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !$past(busy));
endmodule

// File: tb/tb_pgw_top.sv
// Self-checking bench. A behavioural model runs beside the design and is
// compared with it every clock. Directed checks cover the named cases.
module tb_pgw_top;
    localparam int CLK_P = 10;
    localparam int PG    = 16;
    localparam int CYC   = 40;
    localparam int SMP   = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic [15:0] cmd_addr = '0;
    logic        byte_stb = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        cs_rise = 1'b0;
    logic        bit_aligned = 1'b0;
    logic        wr_ok;
    logic        rd_req = 1'b0;
    logic [9:0]  rd_addr = '0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic        mem_we;
    logic [9:0]  mem_addr;
    logic [7:0]  mem_wdata;
    logic        busy;
    logic        wel_clr;

    int checks = 0;
    int errors = 0;
    int prot_lo = 1024;
    bit done = 0;

    // model state
    int m_mem [1024];
    bit m_open = 0;
    int m_page = 0;
    int m_ptr = 0;
    int m_buf [PG];
    bit m_mask [PG];
    bit m_busy = 0;
    int m_step = 0;
    bit m_clr = 0;
    bit m_rv = 0;
    int m_rd = 0;

    assign wr_ok = (int'(mem_addr) < prot_lo);

    always #(CLK_P/2) clk = ~clk;

    pgw_top #(.PAGE_BYTES(PG), .CYCLE_CLKS(CYC)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
        .byte_stb(byte_stb), .byte_data(byte_data), .cs_rise(cs_rise),
        .bit_aligned(bit_aligned), .wr_ok(wr_ok), .rd_req(rd_req),
        .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .busy(busy), .wel_clr(wel_clr)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit any_mask();
        for (int i = 0; i < PG; i++) if (m_mask[i]) return 1'b1;
        return 1'b0;
    endfunction

    // Compare with the model, then advance the model past the next edge.
    always @(negedge clk) begin
        #(SMP);
        if (!done) begin
            int  wa;
            bit  exp_we;
            wa     = m_page * PG + m_step;
            exp_we = m_busy && m_step < PG && m_mask[m_step % PG] && wa < prot_lo;
            chk("R6 busy", int'(busy), int'(m_busy));
            chk("R9 wel_clr", int'(wel_clr), int'(m_clr));
            chk("R7 mem_we", int'(mem_we), int'(exp_we));
            if (exp_we) begin
                chk("R7 mem_addr", int'(mem_addr), wa);
                chk("R7 mem_wdata", int'(mem_wdata), m_buf[m_step]);
            end
            chk("R8 rd_valid", int'(rd_valid), int'(m_rv));
            if (m_rv) chk("R8 rd_data", int'(rd_data), m_rd);

            if (!rst_n) begin
                foreach (m_mem[i]) m_mem[i] = 0;
                foreach (m_mask[i]) begin m_mask[i] = 0; m_buf[i] = 0; end
                m_open = 0; m_busy = 0; m_step = 0; m_clr = 0; m_rv = 0; m_rd = 0;
                m_page = 0; m_ptr = 0;
            end else begin
                m_rv = rd_req && !m_busy;
                if (m_rv) m_rd = m_mem[rd_addr];
                if (m_busy) begin
                    if (exp_we) m_mem[wa] = m_buf[m_step];
                    m_step++;
                    m_clr = (m_step == CYC);
                    if (m_step == CYC) m_busy = 0;
                end else begin
                    m_clr = 0;
                    if (cs_rise) begin
                        if (m_open && bit_aligned && any_mask()) begin
                            m_busy = 1;
                            m_step = 0;
                        end
                        m_open = 0;
                    end else if (cmd_start) begin
                        m_open = 1;
                        m_page = int'(cmd_addr[9:0]) / PG;
                        m_ptr  = int'(cmd_addr[9:0]) % PG;
                        foreach (m_mask[i]) m_mask[i] = 0;
                    end else if (byte_stb && m_open) begin
                        m_buf[m_ptr]  = int'(byte_data);
                        m_mask[m_ptr] = 1;
                        m_ptr = (m_ptr + 1) % PG;
                    end
                end
            end
        end
    end

    task automatic do_start(input logic [15:0] a);
        @(negedge clk); cmd_start = 1'b1; cmd_addr = a;
        @(negedge clk); cmd_start = 1'b0;
    endtask

    task automatic do_byte(input logic [7:0] d);
        @(negedge clk); byte_stb = 1'b1; byte_data = d;
        @(negedge clk); byte_stb = 1'b0;
    endtask

    task automatic do_rise(input logic al, input int exp_busy, input string tag);
        @(negedge clk); cs_rise = 1'b1; bit_aligned = al;
        @(negedge clk); cs_rise = 1'b0; bit_aligned = 1'b0;
        #(SMP + 1);
        chk(tag, int'(busy), exp_busy);
    endtask

    task automatic do_read(input logic [9:0] a, input int exp_v, input int exp_d,
                           input string tag);
        @(negedge clk); rd_req = 1'b1; rd_addr = a;
        @(negedge clk); rd_req = 1'b0;
        #(SMP + 1);
        chk(tag, int'(rd_valid), exp_v);
        if (exp_v != 0) chk(tag, int'(rd_data), exp_d);
    endtask

    // Count busy samples from just after commit; check the clear pulse edge.
    task automatic measure_window(input string tag);
        int n = 0;
        for (int k = 0; k < CYC + 10; k++) begin
            if (busy) n++;
            else if (n > 0) begin
                chk({tag, " R9 pulse"}, int'(wel_clr), 1);
                break;
            end
            @(negedge clk); #(SMP + 1);
        end
        chk({tag, " R6 length"}, n, CYC);
        @(negedge clk); #(SMP + 1);
        chk({tag, " R9 single"}, int'(wel_clr), 0);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_P * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #(SMP + 1);
        chk("R10 busy", int'(busy), 0);
        chk("R10 wel_clr", int'(wel_clr), 0);
        chk("R10 mem_we", int'(mem_we), 0);
        chk("R10 rd_valid", int'(rd_valid), 0);
        do_read(10'h155, 1, 0, "R10 array cleared");

        // R1: upper address bits ignored; R3 commit
        do_start(16'hFC05);
        do_byte(8'hA1); do_byte(8'hA2); do_byte(8'hA3);
        do_rise(1'b1, 1, "R3 commit");
        measure_window("S1");
        do_read(10'h005, 1, 8'hA1, "R1 low address used");
        do_read(10'h007, 1, 8'hA3, "R2 sequential slots");
        do_read(10'h008, 1, 8'h00, "R7 untouched neighbour");

        // R7: single byte leaves the other locations alone
        do_start(16'h0006);
        do_byte(8'h5A);
        do_rise(1'b1, 1, "R3 commit single");
        measure_window("S1b");
        do_read(10'h005, 1, 8'hA1, "R7 old byte kept");
        do_read(10'h006, 1, 8'h5A, "R7 new byte");
        do_read(10'h007, 1, 8'hA3, "R7 old byte kept after");

        // R2: page overrun wraps within the page
        do_start(16'h001E);
        for (int k = 0; k < 20; k++) do_byte(8'(8'h40 + k));
        do_rise(1'b1, 1, "R3 commit overrun");
        measure_window("S2");
        do_read(10'h010, 1, 8'h52, "R2 wrap overwrite");
        do_read(10'h01E, 1, 8'h50, "R2 start slot overwritten");
        do_read(10'h012, 1, 8'h44, "R2 middle slot");
        do_read(10'h020, 1, 8'h00, "R2 next page untouched");

        // R4: unaligned rise discards; stray bytes afterwards ignored
        do_start(16'h0100);
        do_byte(8'h77);
        do_rise(1'b0, 0, "R4 unaligned discard");
        do_byte(8'h88);
        do_rise(1'b1, 0, "R4 closed command");
        do_read(10'h100, 1, 8'h00, "R4 array unchanged");

        // R5: no data bytes, no cycle
        do_start(16'h0200);
        do_rise(1'b1, 0, "R5 empty command");

        // R7: protected addresses skipped
        prot_lo = 'h2F4;
        do_start(16'h02F0);
        for (int k = 0; k < 8; k++) do_byte(8'(8'h90 + k));
        do_rise(1'b1, 1, "R3 commit protected");
        measure_window("S5");
        do_read(10'h2F3, 1, 8'h93, "R7 permitted byte");
        do_read(10'h2F4, 1, 8'h00, "R7 protected byte skipped");
        prot_lo = 1024;

        // R6/R8: traffic during the window is ignored
        do_start(16'h00A0);
        do_byte(8'h11);
        do_rise(1'b1, 1, "R3 commit busy test");
        do_read(10'h005, 0, 0, "R8 read blocked while busy");
        do_start(16'h00B0);
        do_byte(8'h22);
        do_rise(1'b1, 1, "R6 rise during busy");
        repeat (CYC + 4) @(negedge clk);
        #(SMP + 1);
        chk("R6 idle after window", int'(busy), 0);
        do_rise(1'b1, 0, "R6 no command left open");
        do_read(10'h0B0, 1, 8'h00, "R6 busy-time byte dropped");
        do_read(10'h0A0, 1, 8'h11, "R7 committed byte");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule